// File: doc/BRIEF.md
# Glitch-Free Internal Clock Selector

This block produces a system clock from two free-running inputs: a slow 31.25 kHz source and an 8 MHz source. A counter running on the fast source divides it down to six further rates, so a 3-bit code chooses among eight output rates in all. The code can be rewritten through a one-cycle write strobe at any moment, whatever rate currently drives the output.

Every accepted change runs a fixed handover. The output first keeps following the old source until that source's next falling edge. From that edge it is held low. The block then counts eight falling edges of the requested source and only after the eighth does it route that source to the output. A stability flag accompanies the output. Moving off the slow source clears it for a settling delay, and the delay is a parameter counted in fast-source cycles. Moving between two divided or full-rate codes leaves the flag untouched. Landing on the slow source clears the flag, which carries meaning only while a non-zero code is in use.

All control logic runs on the rising edge of the fast source. The slow source enters through a two-flop synchronizer. The full-rate path is gated by an enable that changes only while the fast source is low.

Top module: `intclk_selector`

## Requirements
- R1: After reset the requested and active code is 000, `clk_o` follows the slow source (one rising edge per 256 fast cycles) and `stable_o` is 0.
- R2: Once a handover is complete, `clk_o` runs at the rate of the active code: 000 the slow source, 111 the fast source undivided, and codes 001 to 110 the fast source divided by 64, 32, 16, 8, 4 and 2 in that order.
- R3: A write whose code equals the code already requested is ignored: no handover starts and `clk_o` keeps running without interruption.
- R4: After an accepted change, `clk_o` keeps following the old source until that source's next falling edge, and is held low from then on.
- R5: While held low, `clk_o` stays low until eight falling edges of the requested source have been seen, and follows that source from the next cycle.
- R6: A further accepted change during a handover redirects it to the newest code and restarts the edge count from zero, and `clk_o` stays low until that handover completes.
- R7: When a handover from 000 to a non-zero code completes, `stable_o` stays 0 and rises exactly SETTLE_CYCLES fast cycles after the completing edge.
- R8: A handover between two non-zero codes leaves `stable_o` unchanged, so a set flag stays 1 throughout.
- R9: When a handover to 000 completes, `stable_o` is 0 from that edge on and no settling delay runs.
- R10: `clk_o` never shows a high or low phase shorter than half a fast-source period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | 8 MHz source; clocks all control logic |
| clk_slow | input | 1 | 31.25 kHz source, asynchronous to `clk_fast` |
| rst_n | input | 1 | Synchronous active-low reset, sampled on `clk_fast` |
| wr_en | input | 1 | One-cycle strobe that writes `wr_code` |
| wr_code | input | SEL_W | Requested rate code |
| clk_o | output | 1 | Selected system clock |
| stable_o | output | 1 | Frequency-stable flag, meaningful for non-zero codes |

## Verification
A divided or slow level reaches `clk_o` one fast cycle after the level register holding it changes, and the slow source adds two synchronizer cycles before that. The full-rate path opens or closes at the falling edge after its enable register changes. `stable_o` rises exactly SETTLE_CYCLES edges after the completing edge. A behavioural model in the bench advances on each rising edge and predicts `clk_o` a quarter period into both the high and the low phase, and `stable_o` in the high phase, so every comparison falls between edges. Directed checks count rising edges over windows that are whole multiples of each period, and they wait for handover and settling bounds worked out from the edge counts.

// File: rtl/intclk_pkg.sv
// Package shared by the clock selector: the handover state encoding.
package intclk_pkg;
    // Handover phases: running, waiting for old source to fall, parked low.
    typedef enum logic [1:0] {
        HS_RUN  = 2'd0,
        HS_WAIT = 2'd1,
        HS_PARK = 2'd2
    } hs_state_t;
endpackage

// File: rtl/intclk_sources.sv
// Source level generator.
// What: runs the postscaler counter on the fast clock, synchronizes the slow
// clock, and presents one level bit and one falling-edge pulse per code.
// Assumes: code 0 is the slow source, the top code is the undivided fast
// source (its level is not represented; it falls once every cycle), and code k
// in between divides by 2^(NSRC-1-k).
module intclk_sources #(
    parameter int SEL_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clk_slow,
    output logic [(1<<SEL_W)-1:0]   src_lvl,
    output logic [(1<<SEL_W)-1:0]   src_fall
);
    localparam int NSRC  = 1 << SEL_W;
    localparam int DIV_W = NSRC - 2;

    logic [DIV_W-1:0] div_cnt;
    logic             slow_meta, slow_sync;
    logic [NSRC-2:0]  lvl_d;

    // Postscaler counter: each bit is one divided rate.
    always_ff @(posedge clk) begin
        if (!rst_n) div_cnt <= '0;
        else        div_cnt <= div_cnt + 1'b1;
    end

    // Two-flop synchronizer bringing the slow source into the fast domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slow_meta <= 1'b0;
            slow_sync <= 1'b0;
        end else begin
            slow_meta <= clk_slow;
            slow_sync <= slow_meta;
        end
    end

    assign src_lvl[0]      = slow_sync;
    assign src_lvl[NSRC-1] = 1'b0;

    // Divided codes take counter bits, slowest rate on the lowest code.
    for (genvar k = 1; k <= NSRC - 2; k++) begin : g_div
        assign src_lvl[k] = div_cnt[NSRC-2-k];
    end

    // One-cycle delayed copy of the levels for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_d <= '0;
        else        lvl_d <= src_lvl[NSRC-2:0];
    end

    assign src_fall = {1'b1, lvl_d & ~src_lvl[NSRC-2:0]};
endmodule

// File: rtl/intclk_handover.sv
// Handover sequencer.
// What: holds the requested and active codes, parks the output on the old
// source's falling edge, counts EDGES falls of the new source, then routes it.
// Assumes: src_fall pulses are one fast cycle wide; the top code means the
// undivided fast source, which is passed on as a gate request, not a level.
module intclk_handover
    import intclk_pkg::*;
#(
    parameter int SEL_W = 3,
    parameter int EDGES = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [SEL_W-1:0]              wr_code,
    input  logic [(1<<SEL_W)-1:0]         src_lvl,
    input  logic [(1<<SEL_W)-1:0]         src_fall,
    output logic                          out_lvl,
    output logic                          gate_fast,
    output logic                          done,
    output logic [SEL_W-1:0]              from_code,
    output logic [SEL_W-1:0]              to_code,
    output logic                          parked,
    output logic                          restart,
    output logic [$clog2(EDGES)-1:0]      edge_cnt
);
    localparam int ECNT_W = $clog2(EDGES);
    localparam logic [ECNT_W-1:0] LAST_EDGE = ECNT_W'(EDGES - 1);
    localparam logic [SEL_W-1:0]  FAST_CODE = '1;

    hs_state_t         state_q;
    logic [SEL_W-1:0]  tgt_q, cur_q;
    logic [ECNT_W-1:0] ecnt_q;
    logic              change;

    // Accepted change and completion of the current handover.
    always_comb begin
        change = wr_en && (wr_code != tgt_q);
        done   = (state_q == HS_PARK) && !change && src_fall[tgt_q]
                 && (ecnt_q == LAST_EDGE);
    end

    // Handover state, requested code, active code and edge counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HS_RUN;
            tgt_q   <= '0;
            cur_q   <= '0;
            ecnt_q  <= '0;
        end else begin
            if (change) tgt_q <= wr_code;
            unique case (state_q)
                HS_RUN:  if (change) state_q <= HS_WAIT;
                HS_WAIT: if (src_fall[cur_q]) begin
                    state_q <= HS_PARK;
                    ecnt_q  <= '0;
                end
                HS_PARK: begin
                    if (change) begin
                        ecnt_q <= '0;
                    end else if (src_fall[tgt_q]) begin
                        if (ecnt_q == LAST_EDGE) begin
                            state_q <= HS_RUN;
                            cur_q   <= tgt_q;
                        end else begin
                            ecnt_q <= ecnt_q + 1'b1;
                        end
                    end
                end
                default: state_q <= HS_RUN;
            endcase
        end
    end

    // Output routing: a registered level, or a request to gate the fast clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_lvl   <= 1'b0;
            gate_fast <= 1'b0;
        end else begin
            out_lvl   <= (state_q != HS_PARK) && (cur_q != FAST_CODE)
                         && src_lvl[cur_q];
            gate_fast <= (state_q != HS_PARK) && (cur_q == FAST_CODE);
        end
    end

    assign from_code = cur_q;
    assign to_code   = tgt_q;
    assign parked    = (state_q == HS_PARK);
    assign restart   = change;
    assign edge_cnt  = ecnt_q;
endmodule

// File: rtl/intclk_settle.sv
// Stability flag timer.
// What: on a completed handover off code 0 clears the flag and counts
// SETTLE_CYC fast cycles before setting it; landing on code 0 clears it;
// other handovers leave it alone.
// Assumes: SETTLE_CYC >= 1; done is a one-cycle pulse.
module intclk_settle #(
    parameter int SEL_W      = 3,
    parameter int SETTLE_CYC = 32000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done,
    input  logic [SEL_W-1:0] from_code,
    input  logic [SEL_W-1:0] to_code,
    output logic             stable,
    output logic             settling
);
    localparam int SW = $clog2(SETTLE_CYC + 1);

    logic [SW-1:0] scnt_q;

    // Flag and countdown update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stable   <= 1'b0;
            settling <= 1'b0;
            scnt_q   <= '0;
        end else if (done && (to_code == '0)) begin
            stable   <= 1'b0;
            settling <= 1'b0;
        end else if (done && (from_code == '0)) begin
            stable   <= 1'b0;
            settling <= 1'b1;
            scnt_q   <= SW'(SETTLE_CYC);
        end else if (settling) begin
            if (scnt_q == SW'(1)) begin
                stable   <= 1'b1;
                settling <= 1'b0;
            end else begin
                scnt_q <= scnt_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/intclk_selector.sv
// Glitch-free internal clock selector, top level.
// What: ties together the source generator, the handover sequencer and the
// stability timer, and forms clk_o from a registered level or a gated fast clock.
// Assumes: clk_slow is far slower than clk_fast; writes come from the
// clk_fast domain; reset is synchronous to clk_fast.
module intclk_selector #(
    parameter int SEL_W          = 3,
    parameter int HANDOVER_EDGES = 8,
    parameter int SETTLE_CYCLES  = 32000
) (
    input  logic             clk_fast,
    input  logic             clk_slow,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_code,
    output logic             clk_o,
    output logic             stable_o
);
    localparam int NSRC   = 1 << SEL_W;
    localparam int ECNT_W = $clog2(HANDOVER_EDGES);

    logic [NSRC-1:0]   src_lvl, src_fall;
    logic              out_lvl_q, gate_p, gate_n_q;
    logic              done, parked, restart, settling;
    logic [SEL_W-1:0]  cur_code, tgt_code;
    logic [ECNT_W-1:0] edge_cnt;

    intclk_sources #(.SEL_W(SEL_W)) u_src (
        .clk      (clk_fast),
        .rst_n    (rst_n),
        .clk_slow (clk_slow),
        .src_lvl  (src_lvl),
        .src_fall (src_fall)
    );

    intclk_handover #(.SEL_W(SEL_W), .EDGES(HANDOVER_EDGES)) u_hand (
        .clk       (clk_fast),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_code   (wr_code),
        .src_lvl   (src_lvl),
        .src_fall  (src_fall),
        .out_lvl   (out_lvl_q),
        .gate_fast (gate_p),
        .done      (done),
        .from_code (cur_code),
        .to_code   (tgt_code),
        .parked    (parked),
        .restart   (restart),
        .edge_cnt  (edge_cnt)
    );

    intclk_settle #(.SEL_W(SEL_W), .SETTLE_CYC(SETTLE_CYCLES)) u_settle (
        .clk       (clk_fast),
        .rst_n     (rst_n),
        .done      (done),
        .from_code (cur_code),
        .to_code   (tgt_code),
        .stable    (stable_o),
        .settling  (settling)
    );

    // Fast-path enable retimed to the falling edge so it moves while clk_fast is low.
    always_ff @(negedge clk_fast) begin
        if (!rst_n) gate_n_q <= 1'b0;
        else        gate_n_q <= gate_p;
    end

    assign clk_o = (clk_fast & gate_n_q) | out_lvl_q;
endmodule

// File: rtl/intclk_selector_chk.sv
// Assertion checker for intclk_selector, attached by bind below.
// What: checks parking, restart, and stability-flag rules on clk_fast.
// Assumes: reset is held for at least two clk_fast cycles.
module intclk_selector_chk #(
    parameter int SEL_W  = 3,
    parameter int ECNT_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              parked,
    input logic              restart,
    input logic [ECNT_W-1:0] edge_cnt,
    input logic              out_lvl,
    input logic              gate_n,
    input logic              stable,
    input logic              settling,
    input logic [SEL_W-1:0]  cur_code
);
    AST_PARK_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (parked && $past(parked)) |-> (!out_lvl && !gate_n)); // R5

    AST_RESTART_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (parked && restart) |=> (edge_cnt == '0)); // R6

    AST_FLAG_AFTER_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stable) |-> $past(settling)); // R7

    AST_FLAG_DROPS_ON_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stable) |-> (cur_code == '0)); // R8

    AST_FLAG_LOW_ON_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_code == '0) |-> !stable); // R9
endmodule

bind intclk_selector intclk_selector_chk #(
    .SEL_W  (SEL_W),
    .ECNT_W ($clog2(HANDOVER_EDGES))
) u_chk (
    .clk      (clk_fast),
    .rst_n    (rst_n),
    .parked   (parked),
    .restart  (restart),
    .edge_cnt (edge_cnt),
    .out_lvl  (out_lvl_q),
    .gate_n   (gate_n_q),
    .stable   (stable_o),
    .settling (settling),
    .cur_code (cur_code)
);

// File: tb/intclk_selector_test.sv
// Bench for intclk_selector: behavioural model compared on every clock,
// plus directed rate, flag and pulse-width checks.
module intclk_selector_test;
    localparam int  CLK_PERIOD = 10;
    localparam int  SETTLE     = 200;
    localparam int  SLOW_HALF  = 128;

    logic       clk = 1'b0;
    logic       clk_slow = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_code = 3'd0;
    logic       clk_o, stable_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    intclk_selector #(.SEL_W(3), .HANDOVER_EDGES(8), .SETTLE_CYCLES(SETTLE)) uut (
        .clk_fast (clk),
        .clk_slow (clk_slow),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_code  (wr_code),
        .clk_o    (clk_o),
        .stable_o (stable_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Slow source: toggles every SLOW_HALF fast cycles, away from rising edges.
    initial begin
        forever begin
            repeat (SLOW_HALF) @(negedge clk);
            clk_slow = ~clk_slow;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_cnt, m_s1, m_s2, m_state, m_tgt, m_cur, m_ecnt, m_scnt;
    bit m_lvd[8];
    bit m_outl, m_gp, m_gn, m_stab, m_setl, m_on;

    function automatic bit m_level(input int c);
        int per;
        if (c == 0) return bit'(m_s2);
        if (c == 7) return 1'b0;
        per = 1 << (7 - c);
        return (m_cnt % per) >= (per / 2);
    endfunction

    always @(posedge clk) begin
        bit lv[8];
        bit fl[8];
        bit chg, dn;
        int old_state, old_cur, old_tgt;
        if (!rst_n) begin
            m_cnt = 0; m_s1 = 0; m_s2 = 0; m_state = 0; m_tgt = 0; m_cur = 0;
            m_ecnt = 0; m_scnt = 0; m_outl = 0; m_gp = 0; m_stab = 0; m_setl = 0;
            foreach (m_lvd[i]) m_lvd[i] = 0;
            m_on = 1;
        end else begin
            for (int c = 0; c < 8; c++) lv[c] = m_level(c);
            for (int c = 0; c < 7; c++) fl[c] = m_lvd[c] && !lv[c];
            fl[7] = 1'b1;
            old_state = m_state; old_cur = m_cur; old_tgt = m_tgt;
            chg = wr_en && (int'(wr_code) != old_tgt);
            dn  = 0;
            m_outl = (old_state != 2) && (old_cur != 7) && lv[old_cur];
            m_gp   = (old_state != 2) && (old_cur == 7);
            if (old_state == 0) begin
                if (chg) m_state = 1;
            end else if (old_state == 1) begin
                if (fl[old_cur]) begin m_state = 2; m_ecnt = 0; end
            end else begin
                if (chg) m_ecnt = 0;
                else if (fl[old_tgt]) begin
                    if (m_ecnt == 7) begin dn = 1; m_state = 0; m_cur = old_tgt; end
                    else m_ecnt++;
                end
            end
            if (chg) m_tgt = int'(wr_code);
            if (dn && old_tgt == 0) begin m_stab = 0; m_setl = 0; end
            else if (dn && old_cur == 0) begin m_stab = 0; m_setl = 1; m_scnt = SETTLE; end
            else if (m_setl) begin
                if (m_scnt == 1) begin m_stab = 1; m_setl = 0; end
                else m_scnt--;
            end
            for (int c = 0; c < 7; c++) m_lvd[c] = lv[c];
            m_cnt++;
            m_s2 = m_s1;
            m_s1 = int'(clk_slow);
        end
        #(CLK_PERIOD/4);
        if (m_on && !finished) begin
            check(m_state == 0 ? "R2 clk_o high phase" :
                  m_state == 1 ? "R4 clk_o high phase" : "R5 clk_o high phase",
                  int'(clk_o), int'(m_outl | m_gn));
            check("R7 stable_o", int'(stable_o), int'(m_stab));
        end
    end

    always @(negedge clk) begin
        m_gn = rst_n ? m_gp : 1'b0;
        #(CLK_PERIOD/4);
        if (m_on && !finished)
            check(m_state == 0 ? "R2 clk_o low phase" :
                  m_state == 1 ? "R4 clk_o low phase" : "R5 clk_o low phase",
                  int'(clk_o), int'(m_outl));
    end

    // ---------------- edge counting and pulse widths ----------------
    int  rise_cnt = 0;
    bit  count_on = 0;
    always @(posedge clk_o) if (count_on) rise_cnt++;

    bit      pw_on = 0;
    realtime last_t = 0.0;
    realtime min_w = 1.0e9;
    always @(clk_o) begin
        if (pw_on && last_t > 0.0 && ($realtime - last_t) < min_w) min_w = $realtime - last_t;
        last_t = $realtime;
    end

    task automatic count_rises(input int cycles, output int n);
        @(negedge clk);
        rise_cnt = 0;
        count_on = 1;
        repeat (cycles) @(negedge clk);
        count_on = 0;
        n = rise_cnt;
    endtask

    task automatic write_code(input logic [2:0] c);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_code = c;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic summary;
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 60000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    // ---------------- directed sequence ----------------
    initial begin
        int n, lows, highs;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        pw_on = 1;

        // R1: reset state, slow source running
        check("R1 stable_o after reset", int'(stable_o), 0);
        count_rises(1024, n);
        check("R1 slow rate after reset", n, 4);

        // R7: leaving code 000, flag low then set after settling
        write_code(3'd3);
        repeat (10) @(negedge clk);
        check("R7 stable_o low during switch", int'(stable_o), 0);
        repeat (1000) @(negedge clk);
        check("R7 stable_o set after delay", int'(stable_o), 1);
        count_rises(1024, n);
        check("R2 code 011 divides by 16", n, 64);

        // R3: rewriting the same code must not park the output
        write_code(3'd3);
        count_rises(256, n);
        check("R3 same code keeps running", n, 16);

        // R8: nonzero to nonzero keeps the flag set
        write_code(3'd7);
        lows = 0;
        repeat (300) begin
            @(negedge clk);
            if (!stable_o) lows++;
        end
        check("R8 flag never dropped", lows, 0);
        count_rises(1024, n);
        check("R2 code 111 undivided", n, 1024);

        write_code(3'd6);
        repeat (100) @(negedge clk);
        count_rises(1024, n);
        check("R2 code 110 divides by 2", n, 512);

        // R6: redirect during a handover, output stays low
        write_code(3'd1);
        repeat (5) @(negedge clk);
        write_code(3'd5);
        highs = 0;
        repeat (20) begin
            @(posedge clk); #(CLK_PERIOD/4); if (clk_o) highs++;
            @(negedge clk); #(CLK_PERIOD/4); if (clk_o) highs++;
        end
        check("R6 output held low after redirect", highs, 0);
        repeat (200) @(negedge clk);
        count_rises(1024, n);
        check("R6 lands on latest code 101 (div 4)", n, 256);

        // R9: back to code 000
        write_code(3'd0);
        repeat (2600) @(negedge clk);
        check("R9 flag clear on slow source", int'(stable_o), 0);
        count_rises(1024, n);
        check("R2 code 000 slow rate", n, 4);

        write_code(3'd2);
        repeat (1000) @(negedge clk);
        check("R7 flag set again after leaving 000", int'(stable_o), 1);
        count_rises(1024, n);
        check("R2 code 010 divides by 32", n, 32);

        // R10: shortest observed phase
        check("R10 no phase below half fast period",
              int'(min_w >= real'(CLK_PERIOD) / 2.0), 1);

        summary();
    end
endmodule